// File: doc/BRIEF.md
# ADC Bring-Up Command Sequencer

This block is an SPI host that takes a multichannel delta-sigma converter from power-on to a configured state without help from software. A single start request launches a fixed sequence:

- a reset command;
- a programmable wait;
- a command that stops continuous data output;
- one register write for each entry of a small external register list;
- a register read of the identity register.

The block compares the identity byte it reads with an expected value. It then pulses `done_o` and reports a mismatch on a sticky error flag.

The converter decodes each command byte in a fixed number of its own master-clock periods. For that reason the sequencer spaces the bytes inside a multi-byte command so that the start of one byte and the start of the next are never closer than that decode time. The spacing is derived at elaboration from three parameters: the SCLK divider, the ratio of the system clock to the converter clock, and the number of decode periods. Chip select stays low across a whole command and goes high between commands. SPI runs in mode 0 with the most significant bit first.

Top module: `adc_bringup_seq`

## Requirements
- R1: While reset is held and right after it, `cs_n_o` is 1 and `sclk_o`, `done_o` and `err_o` are 0.
- R2: The bus uses SPI mode 0. SCLK idles low. Each byte goes out MSB first on `mosi_o`, and `mosi_o` holds steady while SCLK is high. `miso_i` is sampled on the rising SCLK edge.
- R3: After a start request the block sends the following commands in this order, each as its own chip-select frame:
  - the single byte 0x06;
  - the single byte 0x11;
  - for each list entry i from 0 to NUM_REGS-1, the three bytes 0x40|addr, 0x00, data, where `rom_entry_i` holds addr in [12:8] and data in [7:0];
  - the three bytes 0x20, 0x00, 0x00.
- R4: At least RESET_WAIT system clocks pass between the last falling SCLK edge of the 0x06 byte and the first rising SCLK edge of the 0x11 byte.
- R5: Inside one command, the first rising SCLK edge of each byte comes at least DECODE_MCLKS*MCLK_DIV system clocks after the first rising SCLK edge of the byte before it.
- R6: `cs_n_o` stays low for every byte of a command. Between commands it is high for at least 2*SCLK_HALF system clocks. SCLK is low whenever `cs_n_o` is high.
- R7: The byte received on `miso_i` during the third byte of the read command is compared with ID_EXPECT. If it differs, `err_o` is 1 from the `done_o` cycle onward.
- R8: `done_o` is high for exactly one cycle, after the read command's frame has closed. `err_o` does not change between that cycle and the next accepted start.
- R9: A start request made while a sequence is running is ignored. The running sequence completes unchanged and no second sequence follows.
- R10: An accepted start request clears `err_o` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| done_o | output | 1 | One-cycle pulse at the end of the sequence |
| err_o | output | 1 | Identity mismatch, held until the next start |
| sclk_o | output | 1 | SPI clock, mode 0 |
| mosi_o | output | 1 | SPI data to the converter |
| miso_i | input | 1 | SPI data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| rom_idx_o | output | IDXW | Index into the register list |
| rom_entry_i | input | 13 | Register-list entry: address [12:8], data [7:0] |

## Verification
The bench runs the sequence three times, under these conditions:

| Run | Register list | Identity byte returned | What the run tells apart |
|-----|---------------|------------------------|--------------------------|
| 1 | first list | matching | correct sequencing |
| 2 | first list | mismatching | error path; a second start mid-sequence must not disturb the frames |
| 3 | second, different list | matching | error clear on start; addresses and data come from the list rather than fixed values |

The first and third runs must leave the error flag low, while the second must raise it and hold it. In the third run, a correct pass shows that the error clears on start.

A slave model times every frame. It measures the byte-to-byte spacing inside each command, the chip-select high time between commands, and the wait after reset. A sequencer that merely emits the right bytes without the decode spacing therefore fails, and so does one that drops the deselect between commands.

// File: rtl/adcb_pkg.sv
// Package: shared states, command kinds and opcodes for the ADC bring-up sequencer.
// Assumes register addresses fit in 5 bits.
package adcb_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_GAP,
        S_CSHI,
        S_WAIT,
        S_DONE
    } seq_state_t;

    typedef enum logic [1:0] {
        K_RESET,
        K_STOP,
        K_WRITE,
        K_READ
    } cmd_kind_t;

    localparam int          REGA_W   = 5;
    localparam int          ENTRY_W  = REGA_W + 8;
    localparam logic [7:0]  OP_RESET = 8'h06;
    localparam logic [7:0]  OP_STOP  = 8'h11;
    localparam logic [7:0]  OP_WREG  = 8'h40;
    localparam logic [7:0]  OP_RREG  = 8'h20;

    // Byte number idx of a command of kind k (the read always targets address 0)
    function automatic logic [7:0] cmd_byte(cmd_kind_t k, logic [1:0] idx,
                                            logic [REGA_W-1:0] addr, logic [7:0] data);
        logic [7:0] b;
        case (k)
            K_RESET: b = OP_RESET;
            K_STOP:  b = OP_STOP;
            K_WRITE: b = (idx == 2'd0) ? (OP_WREG | {3'b000, addr}) :
                         (idx == 2'd1) ? 8'h00 : data;
            default: b = (idx == 2'd0) ? OP_RREG : 8'h00;
        endcase
        return b;
    endfunction

    // Index of the last byte of a command of kind k
    function automatic logic [1:0] cmd_last(cmd_kind_t k);
        return (k == K_WRITE || k == K_READ) ? 2'd2 : 2'd0;
    endfunction

endpackage

// File: rtl/adcb_tick_gen.sv
// Module: free-running divider that marks every HALF-th system clock as one
// half SCLK period. Assumes HALF >= 1; HALF == 1 gives a tick every cycle.
module adcb_tick_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (HALF <= 1) begin : g_every
            // Every cycle is a half period
            assign tick_o = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(HALF);
            logic [CW-1:0] cnt;

            // Count system clocks modulo HALF
            always_ff @(posedge clk) begin
                if (!rst_n)                           cnt <= '0;
                else if (cnt == CW'(HALF - 1))        cnt <= '0;
                else                                  cnt <= cnt + 1'b1;
            end

            assign tick_o = (cnt == CW'(HALF - 1));
        end
    endgenerate

endmodule

// File: rtl/adcb_spi_byte.sv
// Module: mode-0 byte shifter. A load while idle latches one byte. Each tick then
// advances one half SCLK period: the rising half samples MISO, the falling half
// shifts MOSI. done_o pulses on the edge of the eighth falling SCLK.
// Assumes the caller loads only while busy_o is low.
module adcb_spi_byte (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       load_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sclk_o,
    output logic       mosi_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [7:0] rx_o
);

    logic [7:0] sh_q;
    logic [3:0] half_q;

    // Latch, clock out and capture one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            rx_o   <= '0;
            half_q <= '0;
            busy_o <= 1'b0;
            sclk_o <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (load_i && !busy_o) begin
                sh_q   <= tx_i;
                busy_o <= 1'b1;
                half_q <= '0;
                sclk_o <= 1'b0;
            end else if (busy_o && tick_i) begin
                half_q <= half_q + 1'b1;
                if (!half_q[0]) begin
                    sclk_o <= 1'b1;
                    rx_o   <= {rx_o[6:0], miso_i};
                end else begin
                    sclk_o <= 1'b0;
                    sh_q   <= {sh_q[6:0], 1'b0};
                    if (half_q == 4'd15) begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end
                end
            end
        end
    end

    assign mosi_o = sh_q[7];

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);                                       // R2
    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(mosi_o));                                // R2

endmodule

// File: rtl/adcb_seq_fsm.sv
// Module: bring-up sequencer. It walks reset, wait, stop-continuous, one write
// per list entry and the identity read. It drives chip select, feeds bytes to
// the shifter, and holds decode gaps and deselect time, counted in ticks.
// Assumes NUM_REGS >= 1 and a combinational list read.
module adcb_seq_fsm
    import adcb_pkg::*;
#(
    parameter int         NUM_REGS   = 4,
    parameter int         IDXW       = 2,
    parameter int         GAP_TICKS  = 16,
    parameter int         CSHI_TICKS = 3,
    parameter int         RESET_WAIT = 500,
    parameter logic [7:0] ID_EXPECT  = 8'hD0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               done_o,
    output logic               err_o,
    output logic               cs_n_o,
    output logic [IDXW-1:0]    rom_idx_o,
    input  logic [ENTRY_W-1:0] rom_entry_i,
    input  logic               tick_i,
    output logic               byte_load_o,
    output logic [7:0]         byte_tx_o,
    input  logic               byte_done_i,
    input  logic               byte_busy_i,
    input  logic [7:0]         byte_rx_i
);

    localparam int TMAX = (GAP_TICKS > CSHI_TICKS) ? GAP_TICKS : CSHI_TICKS;
    localparam int TW   = $clog2(TMAX + 1) + 1;
    localparam int WW   = $clog2(RESET_WAIT + 1) + 1;

    seq_state_t      state_q;
    cmd_kind_t       kind_q;
    logic [1:0]      bidx_q;
    logic [IDXW-1:0] reg_q;
    logic [TW-1:0]   tcnt_q;
    logic [WW-1:0]   wcnt_q;
    logic            id_ok_q;

    // Current byte comes from the command kind, the byte index and the list entry
    always_comb begin
        byte_tx_o   = cmd_byte(kind_q, bidx_q, rom_entry_i[ENTRY_W-1:8], rom_entry_i[7:0]);
        byte_load_o = (state_q == S_LOAD);
        rom_idx_o   = reg_q;
    end

    // Sequence state, counters, chip select and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            kind_q  <= K_RESET;
            bidx_q  <= '0;
            reg_q   <= '0;
            tcnt_q  <= '0;
            wcnt_q  <= '0;
            id_ok_q <= 1'b0;
            cs_n_o  <= 1'b1;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        err_o   <= 1'b0;
                        kind_q  <= K_RESET;
                        bidx_q  <= '0;
                        reg_q   <= '0;
                        cs_n_o  <= 1'b0;
                        state_q <= S_LOAD;
                    end
                end
                S_LOAD: state_q <= S_SHIFT;
                S_SHIFT: begin
                    if (byte_done_i) begin
                        tcnt_q <= '0;
                        if (kind_q == K_READ && bidx_q == 2'd2)
                            id_ok_q <= (byte_rx_i == ID_EXPECT);
                        state_q <= S_GAP;
                    end
                end
                S_GAP: begin
                    if (tcnt_q == TW'(GAP_TICKS)) begin
                        tcnt_q <= '0;
                        if (bidx_q != cmd_last(kind_q)) begin
                            bidx_q  <= bidx_q + 1'b1;
                            state_q <= S_LOAD;
                        end else begin
                            cs_n_o  <= 1'b1;
                            state_q <= S_CSHI;
                        end
                    end else if (tick_i) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_CSHI: begin
                    if (tcnt_q == TW'(CSHI_TICKS)) begin
                        tcnt_q <= '0;
                        bidx_q <= '0;
                        case (kind_q)
                            K_RESET: begin
                                wcnt_q  <= '0;
                                state_q <= S_WAIT;
                            end
                            K_STOP: begin
                                kind_q  <= K_WRITE;
                                cs_n_o  <= 1'b0;
                                state_q <= S_LOAD;
                            end
                            K_WRITE: begin
                                if (reg_q == IDXW'(NUM_REGS - 1)) kind_q <= K_READ;
                                else                              reg_q  <= reg_q + 1'b1;
                                cs_n_o  <= 1'b0;
                                state_q <= S_LOAD;
                            end
                            default: state_q <= S_DONE;
                        endcase
                    end else if (tick_i) begin
                        tcnt_q <= tcnt_q + 1'b1;
                    end
                end
                S_WAIT: begin
                    if (wcnt_q >= WW'(RESET_WAIT)) begin
                        kind_q  <= K_STOP;
                        cs_n_o  <= 1'b0;
                        state_q <= S_LOAD;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                S_DONE: begin
                    done_o  <= 1'b1;
                    err_o   <= !id_ok_q;
                    state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_CS_LOW_IN_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_busy_i |-> !cs_n_o);                                   // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                        // R8
    AST_ERR_RISES_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);                                   // R7
    AST_ERR_CLEARS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_o) |-> $past(start_i));                           // R10
    AST_RESET_CMD_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LOAD && kind_q == K_RESET) |-> $past(state_q) == S_IDLE); // R9

endmodule

// File: rtl/adc_bringup_seq.sv
// Module: top of the ADC bring-up sequencer. It derives the decode gap from the
// clock ratio and connects the tick divider, the byte shifter and the sequencer.
// Assumes the system clock is MCLK_DIV times the converter master clock.
module adc_bringup_seq
    import adcb_pkg::*;
#(
    parameter int         SCLK_HALF    = 2,
    parameter int         MCLK_DIV     = 16,
    parameter int         DECODE_MCLKS = 4,
    parameter int         RESET_WAIT   = 500,
    parameter int         NUM_REGS     = 4,
    parameter logic [7:0] ID_EXPECT    = 8'hD0,
    localparam int        IDXW         = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               done_o,
    output logic               err_o,
    output logic               sclk_o,
    output logic               mosi_o,
    input  logic               miso_i,
    output logic               cs_n_o,
    output logic [IDXW-1:0]    rom_idx_o,
    input  logic [ENTRY_W-1:0] rom_entry_i
);

    localparam int DECODE_CLKS = DECODE_MCLKS * MCLK_DIV;
    localparam int NEED_TICKS  = (DECODE_CLKS + SCLK_HALF - 1) / SCLK_HALF;
    localparam int GAP_TICKS   = (NEED_TICKS > 16) ? NEED_TICKS - 16 : 0;
    localparam int CSHI_TICKS  = 3;

    logic       tick;
    logic       b_load, b_done, b_busy;
    logic [7:0] b_tx, b_rx;

    adcb_tick_gen #(.HALF(SCLK_HALF)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    adcb_spi_byte u_byte (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .load_i (b_load),
        .tx_i   (b_tx),
        .miso_i (miso_i),
        .sclk_o (sclk_o),
        .mosi_o (mosi_o),
        .busy_o (b_busy),
        .done_o (b_done),
        .rx_o   (b_rx)
    );

    adcb_seq_fsm #(
        .NUM_REGS   (NUM_REGS),
        .IDXW       (IDXW),
        .GAP_TICKS  (GAP_TICKS),
        .CSHI_TICKS (CSHI_TICKS),
        .RESET_WAIT (RESET_WAIT),
        .ID_EXPECT  (ID_EXPECT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .done_o      (done_o),
        .err_o       (err_o),
        .cs_n_o      (cs_n_o),
        .rom_idx_o   (rom_idx_o),
        .rom_entry_i (rom_entry_i),
        .tick_i      (tick),
        .byte_load_o (b_load),
        .byte_tx_o   (b_tx),
        .byte_done_i (b_done),
        .byte_busy_i (b_busy),
        .byte_rx_i   (b_rx)
    );

    AST_SCLK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);                                        // R6

endmodule

// File: tb/adc_bringup_seq_test.sv
// Bench: a behavioural converter-side model records every frame and its timing;
// per-clock checks and per-run byte-stream comparisons against expected queues.
module adc_bringup_seq_test;

    localparam int H      = 2;
    localparam int DEC    = 4 * 16;
    localparam int RWAIT  = 500;
    localparam int NREG   = 4;
    localparam int PER    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done, err, sclk, mosi, miso, cs_n;
    logic [1:0]  rom_idx;
    logic [12:0] rom_entry;
    logic [12:0] rom_tab [NREG];
    logic [7:0]  id_val = 8'hD0;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign rom_entry = rom_tab[rom_idx];

    adc_bringup_seq uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .done_o      (done),
        .err_o       (err),
        .sclk_o      (sclk),
        .mosi_o      (mosi),
        .miso_i      (miso),
        .cs_n_o      (cs_n),
        .rom_idx_o   (rom_idx),
        .rom_entry_i (rom_entry)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input longint act, input longint lim);
        vectors++;
        if (act < lim) begin
            fails++;
            $display("FAIL %s: actual %0d expected >= %0d", req, act, lim);
        end
    endtask

    // ---------------- converter-side model ----------------
    logic     armed = 1'b0;
    int       bitcnt = 0;
    int       bpos = 0;
    logic [7:0] sh_in = 8'h00;
    logic [7:0] first_b = 8'h00;
    logic [7:0] prev_first = 8'h00;
    longint   byte_t0 = 0, prev_t0 = 0, last_fall = 0, cs_rise = 0;
    logic [7:0] got_q[$];
    logic [2:0] mbit;

    assign mbit = 3'(7 - bitcnt);
    assign miso = (!cs_n && bpos == 2 && first_b == 8'h20) ? id_val[mbit] : 1'b0;

    // Capture MOSI on rising SCLK, check in-command spacing (R5) and reset wait (R4)
    always @(posedge sclk) begin
        if (armed) begin
            if (bitcnt == 0) begin
                byte_t0 = $time / PER;
                if (bpos > 0) chk_ge("R5 byte spacing", byte_t0 - prev_t0, DEC);
                if (bpos == 0 && prev_first == 8'h06)
                    chk_ge("R4 reset wait", byte_t0 - last_fall, RWAIT);
                prev_t0 = byte_t0;
            end
            sh_in = {sh_in[6:0], mosi};
            bitcnt++;
            if (bitcnt == 8) begin
                got_q.push_back(sh_in);
                if (bpos == 0) first_b = sh_in;
                bpos++;
                bitcnt = 0;
            end
        end
    end

    always @(negedge sclk) if (armed) last_fall = $time / PER;

    // Frame boundaries: deselect time (R6), partial byte detection (R2)
    always @(negedge cs_n) begin
        if (armed) begin
            if (cs_rise > 0) chk_ge("R6 deselect time", $time / PER - cs_rise, 2 * H);
            bpos = 0;
            bitcnt = 0;
        end
    end

    always @(posedge cs_n) begin
        if (armed) begin
            cs_rise = $time / PER;
            prev_first = first_b;
            if (bitcnt != 0) chk("R2 whole bytes per frame", bitcnt, 0);
        end
    end

    // Per-clock comparison: SCLK low when deselected (R6); done only when expected (R8)
    logic done_ok = 1'b0;
    always @(negedge clk) begin
        if (armed) begin
            if (cs_n && sclk) chk("R6 sclk low while deselected", sclk, 0);
            else vectors++;
            if (done && !done_ok) chk("R8 unexpected done", done, 0);
        end
    end

    // ---------------- stimulus ----------------
    task automatic run_seq(input logic [7:0] id, input logic exp_err, input logic chk_clear);
        logic [7:0] exp_q[$];
        int n;
        exp_q = {8'h06, 8'h11};
        foreach (rom_tab[i]) begin
            exp_q.push_back(8'h40 | {3'b000, rom_tab[i][12:8]});
            exp_q.push_back(8'h00);
            exp_q.push_back(rom_tab[i][7:0]);
        end
        exp_q.push_back(8'h20);
        exp_q.push_back(8'h00);
        exp_q.push_back(8'h00);
        got_q = {};
        id_val = id;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (chk_clear) chk("R10 error cleared by start", err, 0);
        repeat (40) @(negedge clk);
        start = 1'b1;                          // R9: request while busy
        @(negedge clk) start = 1'b0;
        done_ok = 1'b1;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 20000) begin
            fails++;
            vectors++;
            $display("FAIL R8 watchdog: actual no done expected done");
        end else begin
            chk("R7 error flag at done", err, exp_err);
            @(negedge clk);
            chk("R8 done one cycle", done, 0);
            done_ok = 1'b0;
            chk("R3 R9 byte count", got_q.size(), exp_q.size());
            foreach (exp_q[i])
                if (i < got_q.size()) chk($sformatf("R3 byte %0d", i), got_q[i], exp_q[i]);
            repeat (300) @(negedge clk);
            chk("R8 error held", err, exp_err);
            chk("R9 no second sequence", got_q.size(), exp_q.size());
        end
        done_ok = 1'b0;
    endtask

    initial begin
        rom_tab[0] = {5'h01, 8'hF2};
        rom_tab[1] = {5'h02, 8'hE0};
        rom_tab[2] = {5'h03, 8'hEC};
        rom_tab[3] = {5'h05, 8'h10};
        repeat (5) @(negedge clk);
        chk("R1 cs_n in reset", cs_n, 1);
        chk("R1 sclk in reset", sclk, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 err in reset", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        armed = 1'b1;
        chk("R1 cs_n after reset", cs_n, 1);
        chk("R1 err after reset", err, 0);
        run_seq(8'hD0, 1'b0, 1'b0);
        run_seq(8'h5A, 1'b1, 1'b0);
        rom_tab[0] = {5'h1F, 8'h3C};
        rom_tab[1] = {5'h00, 8'hA5};
        rom_tab[2] = {5'h10, 8'h01};
        rom_tab[3] = {5'h0A, 8'h80};
        run_seq(8'hD0, 1'b0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule